// File: doc/BRIEF.md
# ECC Error Logger with Fault Injection

This block is the register-side companion to a 64-bit on-chip memory protected by a single-error-correct, double-error-detect code. The memory's checker reports correctable and uncorrectable events on dedicated inputs. For each class, the block records the address, the 64-bit data and the syndrome of the first failure. It raises a level interrupt through a status register, a mask and a pair of set and clear ports for that mask.

The block also holds a 64-bit flip pattern and a 24-bit countdown. Software loads the pattern, then writes the count, which arms the injector. The block counts accepted memory writes and presents the pattern on an XOR mask output toward the memory write path for exactly one write. Software talks to the block over a plain 32-bit register bus with one cycle of read latency. The encoder and decoder themselves are outside the block.

Top module: `ecc_err_logger`

## Requirements
- R1: After a synchronous reset, the following values hold: control reads 0, status reads 0, mask reads 0xC0 (both classes masked), `irq` is 0, `flip_mask` is 0 and the injector is disarmed.
- R2: `bus_rdata` presents the register selected by `bus_addr` one clock after that address is applied. Write-only offsets and unmapped offsets read 0.
- R3: While control bit 0 (ECC enable) is 0, `ev_ce` and `ev_ue` leave status and all capture registers unchanged.
- R4: While enabled, `ev_ce` sets status bit 6 and `ev_ue` sets status bit 7. When both arrive in one cycle, both bits set and each class captures its own record.
- R5: Writing status with a 1 in bit 6 or bit 7 clears that bit; a 0 leaves it unchanged. When an event of that class arrives in the same cycle as the clearing write, the bit stays set.
- R6: `irq` is high exactly when a status bit in [7:6] is set and its mask bit is clear. Writing a 1 to bit 6 or 7 of the enable offset clears that mask bit. Writing a 1 to bit 6 or 7 of the disable offset sets that mask bit. The mask reads back in bits [7:6].
- R7: A class's capture registers load only when an event of that class arrives while its status bit is clear or being cleared. Later events leave the record unchanged.
- R8: The captured address reads as 0xFFFC0000 OR the 18-bit window offset. The captured data reads as a lower word (bits 31:0) and an upper word (bits 63:32). The syndrome reads in bits [7:0].
- R9: The pattern is written as a lower word (pattern bits 31:0) and an upper word (bits 63:32). `flip_mask` equals the pattern while the injector is armed with count zero, and is 0 otherwise.
- R10: Writing the count offset keeps write-data bits [23:0], ignores bits above 23, and arms the injector. Each `mem_wr` while armed decrements a nonzero count. A `mem_wr` seen with count zero is the injected write: after it, the injector disarms and the count stays 0 until it is rewritten.
- R11: The register offsets are:
  - control 0x00
  - status 0x04
  - mask 0x08
  - enable 0x0C
  - disable 0x10
  - pattern low 0x14
  - pattern high 0x18
  - count 0x1C
  - correctable capture: address 0x20, data low 0x24, data high 0x28, syndrome 0x2C
  - uncorrectable capture: address 0x30, data low 0x34, data high 0x38, syndrome 0x3C

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data |
| ev_ce | input | 1 | Correctable event from the checker |
| ev_ue | input | 1 | Uncorrectable event from the checker |
| ev_addr | input | 18 | Failing offset within the memory window |
| ev_data | input | 64 | Failing data word |
| ev_syn | input | 8 | Failing syndrome |
| mem_wr | input | 1 | Accepted memory write |
| flip_mask | output | 64 | XOR mask for the current memory write |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check four properties on every cycle:
- events are ignored while disabled;
- an enabled uncorrectable event sets its flag;
- a held correctable record does not move;
- a nonzero count decrements on each write, and the pattern leaves the output after it has been consumed.

Only the bench's scenarios can show the rest: the 0xFFFC0000 address composition, the read-back values of every offset, set-over-clear when a clear and an event coincide, and the exact write on which the pattern appears. The bench's cycle model compares read data, interrupt and flip mask against these behaviours on every clock.

// File: rtl/ecc_log_pkg.sv
package ecc_log_pkg;
  localparam int BUS_AW  = 8;
  localparam int BUS_W   = 32;
  localparam int NUM_CLS = 2;
  localparam int CE_BIT  = 6;
  localparam int UE_BIT  = 7;

  localparam logic [BUS_AW-1:0] OFS_CTRL   = 8'h00;
  localparam logic [BUS_AW-1:0] OFS_STAT   = 8'h04;
  localparam logic [BUS_AW-1:0] OFS_MASK   = 8'h08;
  localparam logic [BUS_AW-1:0] OFS_IEN    = 8'h0C;
  localparam logic [BUS_AW-1:0] OFS_IDS    = 8'h10;
  localparam logic [BUS_AW-1:0] OFS_PAT_LO = 8'h14;
  localparam logic [BUS_AW-1:0] OFS_PAT_HI = 8'h18;
  localparam logic [BUS_AW-1:0] OFS_CNT    = 8'h1C;
  localparam logic [BUS_AW-1:0] OFS_CE_ADR = 8'h20;
  localparam logic [BUS_AW-1:0] OFS_CE_DLO = 8'h24;
  localparam logic [BUS_AW-1:0] OFS_CE_DHI = 8'h28;
  localparam logic [BUS_AW-1:0] OFS_CE_SYN = 8'h2C;
  localparam logic [BUS_AW-1:0] OFS_UE_ADR = 8'h30;
  localparam logic [BUS_AW-1:0] OFS_UE_DLO = 8'h34;
  localparam logic [BUS_AW-1:0] OFS_UE_DHI = 8'h38;
  localparam logic [BUS_AW-1:0] OFS_UE_SYN = 8'h3C;
endpackage

// File: rtl/ecc_capture.sv
// First-failure record for one error class.
module ecc_capture #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 64,
  parameter int SYN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              evt,
  input  logic              clr,
  input  logic [ADDR_W-1:0] evt_addr,
  input  logic [DATA_W-1:0] evt_data,
  input  logic [SYN_W-1:0]  evt_syn,
  output logic              flag,
  output logic [ADDR_W-1:0] cap_addr,
  output logic [DATA_W-1:0] cap_data,
  output logic [SYN_W-1:0]  cap_syn
);
  // A record is free when the flag is low or software releases it this cycle.
  logic take;
  assign take = evt && (!flag || clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag     <= 1'b0;
      cap_addr <= '0;
      cap_data <= '0;
      cap_syn  <= '0;
    end else begin
      if (evt)      flag <= 1'b1;
      else if (clr) flag <= 1'b0;
      if (take) begin
        cap_addr <= evt_addr;
        cap_data <= evt_data;
        cap_syn  <= evt_syn;
      end
    end
  end
endmodule

// File: rtl/fault_inject.sv
// Flip pattern and write countdown; the pattern is offered for one write.
module fault_inject #(
  parameter int BUS_W = 32,
  parameter int CNT_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_lo,
  input  logic               wr_hi,
  input  logic               wr_cnt,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               mem_wr,
  output logic [2*BUS_W-1:0] pattern,
  output logic [CNT_W-1:0]   count,
  output logic               armed,
  output logic [2*BUS_W-1:0] flip
);
  localparam int DATA_W = 2 * BUS_W;

  logic fire;
  assign fire = armed && (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pattern <= '0;
      count   <= '0;
      armed   <= 1'b0;
    end else begin
      if (wr_lo) pattern[BUS_W-1:0]      <= wdata;
      if (wr_hi) pattern[DATA_W-1:BUS_W] <= wdata;
      if (wr_cnt) begin
        count <= wdata[CNT_W-1:0];
        armed <= 1'b1;
      end else if (mem_wr && armed) begin
        if (fire) armed <= 1'b0;
        else      count <= count - 1'b1;
      end
    end
  end

  assign flip = fire ? pattern : '0;
endmodule

// File: rtl/ecc_err_logger.sv
module ecc_err_logger
  import ecc_log_pkg::*;
#(
  parameter int          ADDR_W    = 18,
  parameter int          SYN_W     = 8,
  parameter int          CNT_W     = 24,
  parameter logic [31:0] BASE_ADDR = 32'hFFFC0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BUS_AW-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                ev_ce,
  input  logic                ev_ue,
  input  logic [ADDR_W-1:0]   ev_addr,
  input  logic [2*BUS_W-1:0]  ev_data,
  input  logic [SYN_W-1:0]    ev_syn,
  input  logic                mem_wr,
  output logic [2*BUS_W-1:0]  flip_mask,
  output logic                irq
);
  localparam int DATA_W = 2 * BUS_W;

  logic en_q;
  logic [NUM_CLS-1:0] flag, mask_q, clr, evt;
  logic [ADDR_W-1:0]  cap_addr [NUM_CLS];
  logic [DATA_W-1:0]  cap_data [NUM_CLS];
  logic [SYN_W-1:0]   cap_syn  [NUM_CLS];
  logic [DATA_W-1:0]  pattern;
  logic [CNT_W-1:0]   inj_cnt;
  logic               inj_armed;
  logic               wr_ctrl, wr_stat, wr_ien, wr_ids, wr_lo, wr_hi, cnt_wr;
  logic [BUS_W-1:0]   rd_mux;

  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_stat = bus_we && (bus_addr == OFS_STAT);
  assign wr_ien  = bus_we && (bus_addr == OFS_IEN);
  assign wr_ids  = bus_we && (bus_addr == OFS_IDS);
  assign wr_lo   = bus_we && (bus_addr == OFS_PAT_LO);
  assign wr_hi   = bus_we && (bus_addr == OFS_PAT_HI);
  assign cnt_wr  = bus_we && (bus_addr == OFS_CNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (wr_ctrl) en_q <= bus_wdata[0];
      if (wr_ien)       mask_q <= mask_q & ~bus_wdata[UE_BIT:CE_BIT];
      else if (wr_ids)  mask_q <= mask_q |  bus_wdata[UE_BIT:CE_BIT];
    end
  end

  assign clr = {NUM_CLS{wr_stat}} & bus_wdata[UE_BIT:CE_BIT];
  assign evt = {NUM_CLS{en_q}} & {ev_ue, ev_ce};

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_cls
    ecc_capture #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYN_W(SYN_W)
    ) u_cap (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt[k]),
      .clr     (clr[k]),
      .evt_addr(ev_addr),
      .evt_data(ev_data),
      .evt_syn (ev_syn),
      .flag    (flag[k]),
      .cap_addr(cap_addr[k]),
      .cap_data(cap_data[k]),
      .cap_syn (cap_syn[k])
    );
  end

  fault_inject #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_inj (
    .clk    (clk),
    .rst    (rst),
    .wr_lo  (wr_lo),
    .wr_hi  (wr_hi),
    .wr_cnt (cnt_wr),
    .wdata  (bus_wdata),
    .mem_wr (mem_wr),
    .pattern(pattern),
    .count  (inj_cnt),
    .armed  (inj_armed),
    .flip   (flip_mask)
  );

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      OFS_CTRL:   rd_mux[0] = en_q;
      OFS_STAT:   rd_mux[UE_BIT:CE_BIT] = flag;
      OFS_MASK:   rd_mux[UE_BIT:CE_BIT] = mask_q;
      OFS_PAT_LO: rd_mux = pattern[BUS_W-1:0];
      OFS_PAT_HI: rd_mux = pattern[DATA_W-1:BUS_W];
      OFS_CNT:    rd_mux = BUS_W'(inj_cnt);
      OFS_CE_ADR: rd_mux = BASE_ADDR | BUS_W'(cap_addr[0]);
      OFS_CE_DLO: rd_mux = cap_data[0][BUS_W-1:0];
      OFS_CE_DHI: rd_mux = cap_data[0][DATA_W-1:BUS_W];
      OFS_CE_SYN: rd_mux = BUS_W'(cap_syn[0]);
      OFS_UE_ADR: rd_mux = BASE_ADDR | BUS_W'(cap_addr[1]);
      OFS_UE_DLO: rd_mux = cap_data[1][BUS_W-1:0];
      OFS_UE_DHI: rd_mux = cap_data[1][DATA_W-1:BUS_W];
      OFS_UE_SYN: rd_mux = BUS_W'(cap_syn[1]);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  assign irq = |(flag & ~mask_q);
endmodule

// File: rtl/ecc_err_logger_chk.sv
module ecc_err_logger_chk #(
  parameter int ADDR_W = 18,
  parameter int CNT_W  = 24,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic [1:0]        flag,
  input logic [1:0]        clr,
  input logic              ev_ce,
  input logic              ev_ue,
  input logic [ADDR_W-1:0] ce_addr,
  input logic              mem_wr,
  input logic              cnt_wr,
  input logic              armed,
  input logic [CNT_W-1:0]  cnt,
  input logic [DATA_W-1:0] flip,
  input logic              irq
);
  // R1: outputs are quiet on the cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq && flip == '0));

  // R3: no flag rises from an event while disabled
  assert_disabled_R3: assert property (@(posedge clk) disable iff (rst)
    (!en && !rst) |=> !$rose(flag[0]) && !$rose(flag[1]));

  // R4: an enabled uncorrectable event sets its flag
  assert_ue_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (en && ev_ue) |=> flag[1]);

  // R7: a held correctable record stays put
  assert_first_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (flag[0] && !clr[0]) |=> $stable(ce_addr));

  // R10: armed nonzero count steps down on each write
  assert_count_step_R10: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt != '0 && mem_wr && !cnt_wr) |=> cnt == $past(cnt) - 1'b1);

  // R10: the pattern is consumed by one write
  assert_single_shot_R10: assert property (@(posedge clk) disable iff (rst)
    (flip != '0 && mem_wr && !cnt_wr) |=> flip == '0);
endmodule

bind ecc_err_logger ecc_err_logger_chk #(
  .ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
) i_chk (
  .clk    (clk),
  .rst    (rst),
  .en     (en_q),
  .flag   (flag),
  .clr    (clr),
  .ev_ce  (ev_ce),
  .ev_ue  (ev_ue),
  .ce_addr(cap_addr[0]),
  .mem_wr (mem_wr),
  .cnt_wr (cnt_wr),
  .armed  (inj_armed),
  .cnt    (inj_cnt),
  .flip   (flip_mask),
  .irq    (irq)
);

// File: tb/test_ecc_err_logger.sv
module test_ecc_err_logger;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ev_ce = 1'b0, ev_ue = 1'b0;
  logic [17:0] ev_addr = '0;
  logic [63:0] ev_data = '0;
  logic [7:0]  ev_syn = '0;
  logic        mem_wr = 1'b0;
  logic [63:0] flip_mask;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit started = 1'b0;

  ecc_err_logger i_ecc_err_logger (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_ce(ev_ce), .ev_ue(ev_ue),
    .ev_addr(ev_addr), .ev_data(ev_data), .ev_syn(ev_syn), .mem_wr(mem_wr),
    .flip_mask(flip_mask), .irq(irq)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_en;
  bit [1:0]    m_st, m_mk;
  int unsigned m_adr[2], m_syn[2];
  logic [63:0] m_dat[2];
  logic [63:0] m_pat;
  int unsigned m_cnt;
  bit          m_arm;
  logic [31:0] m_rd;

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return {31'd0, m_en};
      8'h04: return {24'd0, m_st, 6'd0};
      8'h08: return {24'd0, m_mk, 6'd0};
      8'h14: return m_pat[31:0];
      8'h18: return m_pat[63:32];
      8'h1C: return m_cnt;
      8'h20: return 32'hFFFC0000 | m_adr[0];
      8'h24: return m_dat[0][31:0];
      8'h28: return m_dat[0][63:32];
      8'h2C: return m_syn[0];
      8'h30: return 32'hFFFC0000 | m_adr[1];
      8'h34: return m_dat[1][31:0];
      8'h38: return m_dat[1][63:32];
      8'h3C: return m_syn[1];
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_en = 0; m_st = 0; m_mk = 2'b11; m_pat = 0; m_cnt = 0; m_arm = 0; m_rd = 0;
      for (int k = 0; k < 2; k++) begin m_adr[k] = 0; m_syn[k] = 0; m_dat[k] = 0; end
    end else begin
      bit [1:0] ev, cl;
      m_rd = model_read(bus_addr);
      ev = {ev_ue, ev_ce} & {2{m_en}};
      cl = (bus_we && bus_addr == 8'h04) ? bus_wdata[7:6] : 2'b00;
      for (int k = 0; k < 2; k++) begin
        if (ev[k] && (!m_st[k] || cl[k])) begin
          m_adr[k] = ev_addr; m_dat[k] = ev_data; m_syn[k] = ev_syn;
        end
        if (ev[k]) m_st[k] = 1; else if (cl[k]) m_st[k] = 0;
      end
      if (bus_we) begin
        case (bus_addr)
          8'h00: m_en = bus_wdata[0];
          8'h0C: m_mk = m_mk & ~bus_wdata[7:6];
          8'h10: m_mk = m_mk | bus_wdata[7:6];
          8'h14: m_pat[31:0] = bus_wdata;
          8'h18: m_pat[63:32] = bus_wdata;
          default: ;
        endcase
      end
      if (bus_we && bus_addr == 8'h1C) begin
        m_cnt = bus_wdata & 32'h00FF_FFFF; m_arm = 1;
      end else if (mem_wr && m_arm) begin
        if (m_cnt == 0) m_arm = 0; else m_cnt = m_cnt - 1;
      end
    end
    started = 1'b1;
  end

  always @(negedge clk) begin
    if (started) begin
      check("R2 model rdata", {32'd0, bus_rdata}, {32'd0, m_rd});
      check("R6 model irq", {63'd0, irq}, {63'd0, |(m_st & ~m_mk)});
      check("R9 model flip", flip_mask, (m_arm && m_cnt == 0) ? m_pat : 64'd0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_addr = a;
    @(negedge clk); check(tag, {32'd0, bus_rdata}, {32'd0, exp});
  endtask

  task automatic event_pulse(input bit ce, input bit ue, input logic [17:0] a,
                             input logic [63:0] d, input logic [7:0] s);
    @(negedge clk); ev_ce = ce; ev_ue = ue; ev_addr = a; ev_data = d; ev_syn = s;
    @(negedge clk); ev_ce = 1'b0; ev_ue = 1'b0;
  endtask

  task automatic mem_pulse();
    @(negedge clk); mem_wr = 1'b1;
    @(negedge clk); mem_wr = 1'b0;
  endtask

  initial begin
    #(PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    rd(8'h04, 32'h0, "R1 status after reset");
    rd(8'h08, 32'hC0, "R1 mask after reset");
    check("R1 irq after reset", {63'd0, irq}, 64'd0);
    check("R1 flip after reset", flip_mask, 64'd0);
    // R2: unmapped and write-only offsets read zero
    rd(8'h0C, 32'h0, "R2 enable offset reads zero");
    rd(8'h44, 32'h0, "R2 unmapped reads zero");
    // R3: ignored while disabled
    event_pulse(1, 1, 18'h00055, 64'hDEAD, 8'h11);
    rd(8'h04, 32'h0, "R3 status while disabled");
    rd(8'h20, 32'hFFFC0000, "R3 capture untouched while disabled");
    // R4 / R8: correctable capture
    wr(8'h00, 32'h1);
    rd(8'h00, 32'h1, "R11 control readback");
    event_pulse(1, 0, 18'h00123, 64'h1111_2222_3333_4444, 8'h5A);
    rd(8'h04, 32'h40, "R4 correctable flag");
    rd(8'h20, 32'hFFFC0123, "R8 address composition");
    rd(8'h24, 32'h3333_4444, "R8 data low");
    rd(8'h28, 32'h1111_2222, "R8 data high");
    rd(8'h2C, 32'h5A, "R8 syndrome");
    // R6: masked then unmasked
    check("R6 irq while masked", {63'd0, irq}, 64'd0);
    wr(8'h0C, 32'hC0);
    check("R6 irq after enable", {63'd0, irq}, 64'd1);
    rd(8'h08, 32'h0, "R6 mask cleared");
    // R7: later event keeps first record
    event_pulse(1, 0, 18'h3FFFF, 64'h9, 8'h01);
    rd(8'h20, 32'hFFFC0123, "R7 first record held");
    // R5: W1C
    wr(8'h04, 32'h00);
    rd(8'h04, 32'h40, "R5 zero write keeps flag");
    wr(8'h04, 32'h40);
    rd(8'h04, 32'h0, "R5 one write clears flag");
    check("R6 irq after clear", {63'd0, irq}, 64'd0);
    // R4: simultaneous classes
    event_pulse(1, 1, 18'h00200, 64'hAAAA_BBBB_CCCC_DDDD, 8'h33);
    rd(8'h04, 32'hC0, "R4 both flags");
    rd(8'h30, 32'hFFFC0200, "R4 uncorrectable address");
    rd(8'h20, 32'hFFFC0200, "R7 new record after clear");
    rd(8'h38, 32'hAAAA_BBBB, "R8 uncorrectable data high");
    // R6: disable one class
    wr(8'h10, 32'h80);
    rd(8'h08, 32'h80, "R6 mask set by disable");
    wr(8'h04, 32'h40);
    check("R6 irq with only masked flag", {63'd0, irq}, 64'd0);
    // R5: clear coinciding with event keeps flag, R7 record reloads
    @(negedge clk);
    bus_addr = 8'h04; bus_we = 1'b1; bus_wdata = 32'hC0;
    ev_ce = 1'b1; ev_addr = 18'h00777; ev_data = 64'h7; ev_syn = 8'h77;
    @(negedge clk); bus_we = 1'b0; ev_ce = 1'b0;
    rd(8'h04, 32'h40, "R5 set wins over clear");
    rd(8'h20, 32'hFFFC0777, "R7 record reloads during clear");
    // R9 / R10: injection
    wr(8'h14, 32'h0000_0001);
    wr(8'h18, 32'h8000_0000);
    rd(8'h18, 32'h8000_0000, "R9 pattern high readback");
    wr(8'h1C, 32'hFF00_0002);
    rd(8'h1C, 32'h2, "R10 upper count bits ignored");
    check("R9 no flip while counting", flip_mask, 64'd0);
    mem_pulse();
    mem_pulse();
    rd(8'h1C, 32'h0, "R10 counted down");
    check("R9 flip presented", flip_mask, 64'h8000_0000_0000_0001);
    mem_pulse();
    check("R10 single shot", flip_mask, 64'd0);
    mem_pulse();
    rd(8'h1C, 32'h0, "R10 count stays zero");
    wr(8'h1C, 32'h0);
    check("R10 zero count arms immediately", flip_mask, 64'h8000_0000_0000_0001);
    mem_pulse();
    check("R10 consumed after rearm", flip_mask, 64'd0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule